// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar in packed BCD registers: seconds, minutes, hours, day of week, date, month and two-digit year. A one-cycle enable pulse at 32.768 kHz feeds a binary prescaler. Each time the prescaler wraps, it advances the seconds, and the carries ripple up through minutes, hours, day and date, month and year. The hours register can run in a 24-hour format or in a 12-hour format with an AM/PM flag. The date rolls over at the true length of each month, and every year divisible by four is treated as a leap year.

Software reaches the registers through a byte-wide port. Writes take effect at the clock edge. Reads are served from a snapshot bank, which is loaded from the live counters when a read access starts and then holds still for the rest of the access, so the bytes of a multi-byte read always belong to one instant. A control byte gates a 1 Hz square-wave output taken from the prescaler.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count 0x00..0x59 in packed BCD. Each wraps to 0x00 and carries into the next field. A step ripples through all fields in the same clock edge.
- R2: With hours bit 6 clear (24-hour format), hours count 0x00..0x23. The step from 0x23 to 0x00 advances both the day of week and the date.
- R3: With hours bit 6 set (12-hour format), bits 4..0 hold 01..12 in BCD and bit 5 is 1 for PM. The sequence is 11 AM to 12 PM, 12 to 01 with the flag unchanged, and 11 PM to 12 AM. Day and date advance only at the 11 PM to 12 AM step.
- R4: Date runs 0x01 up to the month length: 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other non-February months. The date then returns to 0x01 and the month advances. Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R5: February has 0x29 days when the year value is divisible by 4, and 0x28 days otherwise.
- R6: Day of week counts 1..7 and wraps from 7 to 1 at midnight.
- R7: One seconds step happens on every 2^DIV_W-th tick_i pulse. A write to the seconds address (0) clears the prescaler, so the next step comes after exactly 2^DIV_W further ticks.
- R8: hz_oe_o equals control bit 2 (address 7). hz_o is low for the first half of each second (counting from the prescaler clear) and high for the second half.
- R9: A rd_start_i pulse copies all seven time bytes into the snapshot. rd_data_o for addresses 0..6 returns the snapshot, which stays unchanged while the live counters keep running until the next rd_start_i.
- R10: Bits fixed at zero read back as 0 whatever was written. The write masks are 0x7F for seconds, minutes and hours, 0x07 for day of week, 0x3F for date, 0x1F for month, 0xFF for year and 0x04 for control.
- R11: After reset the registers hold 00:00:00 in 24-hour format, day 1, date 01, month 01, year 00, with control 0x00 and the 1 Hz output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 3 | Register address: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 control |
| wr_data_i | input | 8 | Write data |
| rd_start_i | input | 1 | Start of a read access; loads the snapshot |
| rd_data_o | output | 8 | Read data for addr_i (snapshot bytes or live control byte) |
| hz_o | output | 1 | 1 Hz square wave |
| hz_oe_o | output | 1 | Output enable for hz_o; 0 means high impedance |

## Verification
The range assertions assume that software writes only legal BCD values: a valid hour for the selected format, a date that fits the month, and a day of week of 1..7. They also assume that no write shares a clock edge with a tick_i pulse. The stimulus builds every time and date from integer fields drawn inside their legal ranges, with extra weight on the values just before a rollover. It drives tick_i low during all register writes, so the live chain never receives a step and a write in the same edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NREG   = 7;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned HZ_BIT = 2;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd7;

  localparam logic [7:0] CTRL_MASK = 8'h04;

  function automatic logic [7:0] wr_mask(input logic [ADDR_W-1:0] a);
    case (a)
      A_SEC, A_MIN, A_HOUR: wr_mask = 8'h7F;
      A_DOW:                wr_mask = 8'h07;
      A_DATE:               wr_mask = 8'h3F;
      A_MON:                wr_mask = 8'h1F;
      A_YEAR:               wr_mask = 8'hFF;
      default:              wr_mask = CTRL_MASK;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last legal date of the month, BCD; leap rule valid for 2000..2099
  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] ybin;
    ybin = ({4'd0, yr[7:4]} << 3) + ({4'd0, yr[7:4]} << 1) + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      month_len = (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
      default:                    month_len = 8'h31;
    endcase
  endfunction

  // returns {day_roll, next_hour}
  function automatic logic [8:0] hour_advance(input logic [7:0] h);
    logic [7:0] t;
    logic       pm;
    pm = h[5];
    if (h[6]) begin
      if (h[4:0] == 5'h11)      hour_advance = {pm, 2'b01, ~pm, 5'h12};
      else if (h[4:0] == 5'h12) hour_advance = {1'b0, 2'b01, pm, 5'h01};
      else begin
        t = bcd_inc({3'd0, h[4:0]});
        hour_advance = {1'b0, 2'b01, pm, t[4:0]};
      end
    end else begin
      if (h[5:0] == 6'h23) hour_advance = {1'b1, 8'h00};
      else begin
        t = bcd_inc({2'd0, h[5:0]});
        hour_advance = {1'b0, 2'b00, t[5:0]};
      end
    end
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic             step_o,
  output logic [DIV_W-1:0] div_o,
  output logic             sq_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (tick_i) div_q <= div_q + 1'b1;
  end

  assign step_o = tick_i && !clr_i && (div_q == {DIV_W{1'b1}});
  assign div_o  = div_q;
  assign sq_o   = div_q[DIV_W-1];
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [7:0]               data_i,
  output logic [NREG-1:0][7:0]     time_o
);
  logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
  logic       sec_wrap, min_wrap, date_wrap, mon_wrap, day_roll;
  logic [8:0] hour_nx;
  logic [7:0] wdat;

  always_comb begin
    sec_wrap  = (sec_q == 8'h59);
    min_wrap  = (min_q == 8'h59);
    hour_nx   = hour_advance(hour_q);
    day_roll  = sec_wrap && min_wrap && hour_nx[8];
    date_wrap = (date_q >= month_len(mon_q, year_q));
    mon_wrap  = (mon_q == 8'h12);
    wdat      = data_i & wr_mask(addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (wr_en_i) begin
      case (addr_i)
        A_SEC:   sec_q  <= wdat;
        A_MIN:   min_q  <= wdat;
        A_HOUR:  hour_q <= wdat;
        A_DOW:   dow_q  <= wdat;
        A_DATE:  date_q <= wdat;
        A_MON:   mon_q  <= wdat;
        A_YEAR:  year_q <= wdat;
        default: ;
      endcase
    end else if (step_i) begin
      sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (sec_wrap) begin
        min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
        if (min_wrap) hour_q <= hour_nx[7:0];
      end
      if (day_roll) begin
        dow_q  <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
        date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
        if (date_wrap) begin
          mon_q <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
          if (mon_wrap) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end
      end
    end
  end

  assign time_o = {year_q, mon_q, date_q, dow_q, hour_q, min_q, sec_q};
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot #(
  parameter int unsigned N = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [N-1:0][7:0]  live_i,
  output logic [N-1:0][7:0]  snap_o
);
  for (genvar i = 0; i < N; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    snap_o[i] <= 8'h00;
      else if (cap_i) snap_o[i] <= live_i[i];
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_start_i,
  output logic [7:0]        rd_data_o,
  output logic              hz_o,
  output logic              hz_oe_o
);
  logic                 wr_time, wr_sec, wr_ctrl, sec_step, sq;
  logic [DIV_W-1:0]     div_q;
  logic [7:0]           ctrl_q;
  logic [NREG-1:0][7:0] live_time, snap_time;

  assign wr_time = wr_en_i && (addr_i != A_CTRL);
  assign wr_sec  = wr_en_i && (addr_i == A_SEC);
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);

  rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (wr_sec),
    .step_o (sec_step),
    .div_o  (div_q),
    .sq_o   (sq)
  );

  rtc_time_chain u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (sec_step),
    .wr_en_i (wr_time),
    .addr_i  (addr_i),
    .data_i  (wr_data_i),
    .time_o  (live_time)
  );

  rtc_snapshot #(.N(NREG)) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (rd_start_i),
    .live_i (live_time),
    .snap_o (snap_time)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 8'h00;
    else if (wr_ctrl) ctrl_q <= wr_data_i & CTRL_MASK;
  end

  always_comb begin
    if (addr_i == A_CTRL) rd_data_o = ctrl_q;
    else                  rd_data_o = snap_time[addr_i];
  end

  assign hz_o    = sq;
  assign hz_oe_o = ctrl_q[HZ_BIT];
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int unsigned DIV_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       addr_i,
  input logic             rd_start_i,
  input logic             step,
  input logic [DIV_W-1:0] div,
  input logic [6:0][7:0]  live,
  input logic [6:0][7:0]  snap
);
  AST_SEC_BCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live[0][3:0] <= 4'd9) && (live[0] <= 8'h59)); // R1

  AST_HOUR_12H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live[2][6] |-> (live[2][4:0] != 5'h00) && (live[2][4:0] <= 5'h12) && (live[2][3:0] <= 4'd9)); // R3

  AST_DATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live[4] != 8'h00) && (live[4] <= 8'h31) && (live[5] != 8'h00) && (live[5] <= 8'h12)); // R4

  AST_DOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live[3] >= 8'h01) && (live[3] <= 8'h07)); // R6

  AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0) |=> (div == '0)); // R7

  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !step) |=> $stable(live[0])); // R7

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_start_i |=> $stable(snap)); // R9
endmodule

bind rtc_calendar rtc_calendar_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .rd_start_i (rd_start_i),
  .step       (sec_step),
  .div        (div_q),
  .live       (live_time),
  .snap       (snap_time)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int DIV_W = 3;
  localparam int TPS   = 1 << DIV_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_start = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data;
  logic       hz, hz_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench time model
  int s, m, h, pm, md12, dw, dt, mo, yr;

  always #4 clk = ~clk;

  rtc_calendar #(.DIV_W(DIV_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_start_i(rd_start),
    .rd_data_o(rd_data), .hz_o(hz), .hz_oe_o(hz_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] b2(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mon, input int y);
    if (mon == 2) return (y % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_enc();
    if (md12 != 0) return 8'h40 | 8'(pm << 5) | b2(h);
    return b2(h);
  endfunction

  task automatic model_step();
    bit roll;
    roll = 0;
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0;
        if (md12 != 0) begin
          if (h == 11) begin h = 12; roll = (pm == 1); pm = 1 - pm; end
          else if (h == 12) h = 1;
          else h++;
        end else begin
          h++;
          if (h == 24) begin h = 0; roll = 1; end
        end
      end
    end
    if (roll) begin
      dw = (dw == 7) ? 1 : dw + 1;
      dt++;
      if (dt > dim(mo, yr)) begin
        dt = 1; mo++;
        if (mo > 12) begin mo = 1; yr = (yr + 1) % 100; end
      end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); tick = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic snap();
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load_all();
    wr(3'd0, b2(s));
    wr(3'd1, b2(m));
    wr(3'd2, hour_enc());
    wr(3'd3, b2(dw));
    wr(3'd4, b2(dt));
    wr(3'd5, b2(mo));
    wr(3'd6, b2(yr));
  endtask

  task automatic compare(input string req);
    logic [7:0] v;
    snap();
    rd(3'd0, v); check({req, " sec"},  v, b2(s));
    rd(3'd1, v); check({req, " min"},  v, b2(m));
    rd(3'd2, v); check({req, " hour"}, v, hour_enc());
    rd(3'd3, v); check({req, " dow"},  v, b2(dw));
    rd(3'd4, v); check({req, " date"}, v, b2(dt));
    rd(3'd5, v); check({req, " mon"},  v, b2(mo));
    rd(3'd6, v); check({req, " year"}, v, b2(yr));
  endtask

  task automatic run_case(input string req, input int nsteps);
    load_all();
    ticks(TPS * nsteps);
    for (int k = 0; k < nsteps; k++) model_step();
    compare(req);
  endtask

  task automatic set_t(input int a_md12, input int a_pm, input int a_h, input int a_m,
                       input int a_s, input int a_dw, input int a_dt, input int a_mo, input int a_yr);
    md12 = a_md12; pm = a_pm; h = a_h; m = a_m; s = a_s;
    dw = a_dw; dt = a_dt; mo = a_mo; yr = a_yr;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    set_t(0, 0, 0, 0, 0, 1, 1, 1, 0);
    compare("R11");
    rd(3'd7, v); check("R11 ctrl", v, 8'h00);
    check("R11 hz_oe", {7'd0, hz_oe}, 8'h00);

    // R10 fixed-zero bits
    wr(3'd3, 8'hFF); snap(); rd(3'd3, v); check("R10 dow mask", v, 8'h07);
    wr(3'd7, 8'hFF); rd(3'd7, v); check("R10 ctrl mask", v, 8'h04);

    // R8 square wave and enable
    check("R8 oe on", {7'd0, hz_oe}, 8'h01);
    wr(3'd0, 8'h00);
    ticks(TPS / 2 - 1); #1 check("R8 low half", {7'd0, hz}, 8'h00);
    ticks(1);           #1 check("R8 high half", {7'd0, hz}, 8'h01);
    ticks(TPS / 2 - 1); #1 check("R8 high end", {7'd0, hz}, 8'h01);
    ticks(1);           #1 check("R8 wrap low", {7'd0, hz}, 8'h00);
    wr(3'd7, 8'h00); #1 check("R8 oe off", {7'd0, hz_oe}, 8'h00);

    // R7 seconds write restarts prescaler
    set_t(0, 0, 10, 20, 30, 2, 5, 6, 21);
    load_all();
    ticks(TPS / 2);
    wr(3'd0, 8'h30);
    ticks(TPS - 1); snap(); rd(3'd0, v); check("R7 no step yet", v, 8'h30);
    ticks(1);       snap(); rd(3'd0, v); check("R7 step", v, 8'h31);

    // R9 snapshot holds while counters run
    set_t(0, 0, 8, 0, 10, 3, 9, 9, 22);
    load_all(); snap();
    ticks(2 * TPS);
    rd(3'd0, v); check("R9 snapshot held", v, 8'h10);
    snap(); rd(3'd0, v); check("R9 snapshot refresh", v, 8'h12);

    // directed rollovers
    set_t(0, 0, 0, 0, 58, 1, 1, 1, 0); run_case("R1 sec carry", 3);
    set_t(0, 0, 5, 59, 59, 1, 1, 1, 0); run_case("R1 min carry", 1);
    set_t(0, 0, 19, 59, 59, 2, 3, 3, 3); run_case("R2 19 to 20", 1);
    set_t(0, 0, 23, 59, 59, 2, 3, 3, 3); run_case("R2 midnight", 1);
    set_t(1, 0, 11, 59, 59, 4, 10, 10, 10); run_case("R3 11am to 12pm", 1);
    set_t(1, 1, 12, 59, 59, 4, 10, 10, 10); run_case("R3 12pm to 1pm", 1);
    set_t(1, 1, 11, 59, 59, 4, 10, 10, 10); run_case("R3 11pm to 12am", 1);
    set_t(1, 0, 12, 59, 59, 4, 10, 10, 10); run_case("R3 12am to 1am", 1);
    set_t(0, 0, 23, 59, 59, 5, 30, 4, 7); run_case("R4 30-day month", 1);
    set_t(0, 0, 23, 59, 59, 5, 30, 1, 7); run_case("R4 31-day month", 1);
    set_t(0, 0, 23, 59, 59, 5, 31, 12, 99); run_case("R4 year wrap", 1);
    set_t(0, 0, 23, 59, 59, 6, 28, 2, 24); run_case("R5 leap 28", 1);
    set_t(0, 0, 23, 59, 59, 6, 29, 2, 24); run_case("R5 leap 29", 1);
    set_t(0, 0, 23, 59, 59, 6, 28, 2, 23); run_case("R5 common 28", 1);
    set_t(0, 0, 23, 59, 59, 7, 28, 2, 0);  run_case("R5 year 00", 1);
    set_t(0, 0, 23, 59, 59, 7, 12, 8, 50); run_case("R6 dow wrap", 1);

    // random legal times with bias toward rollover points
    for (int it = 0; it < 80; it++) begin
      md12 = $urandom % 2;
      pm   = $urandom % 2;
      if (md12 != 0) h = ($urandom % 2) ? 11 + ($urandom % 2) : 1 + ($urandom % 12);
      else           h = ($urandom % 2) ? 23 : ($urandom % 24);
      m  = ($urandom % 2) ? 59 : ($urandom % 60);
      s  = ($urandom % 2) ? 58 + ($urandom % 2) : ($urandom % 60);
      dw = 1 + ($urandom % 7);
      mo = ($urandom % 3 == 0) ? 12 : 1 + ($urandom % 12);
      yr = ($urandom % 3 == 0) ? 99 : ($urandom % 100);
      dt = ($urandom % 2) ? dim(mo, yr) : 1 + ($urandom % dim(mo, yr));
      run_case("R1 R2 R3 R4 R5 R6 random", 1 + ($urandom % 3));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule